// File: doc/BRIEF.md
# Bus clock and reset sequencer

This block produces the CPU and peripheral bus timing as single-cycle enable pulses inside one system clock domain. Two source strobes arrive at its inputs, one marking each oscillator edge and one marking each PLL edge. A select input picks one of them, and a two-stage divider yields one bus pulse for every four selected source ticks. The CPU enable and the peripheral enable are produced separately. In wait mode the peripherals keep their pulses while the CPU enable stays low. In stop mode both enables are held low.

A hold counter counts oscillator ticks only, whichever source is selected. After a power-on or low-voltage cause it keeps both enables low for the power-up period and drives the active-low reset output low for the whole of that period. When stop mode ends through an interrupt, break or reset wake, the counter keeps the enables off for a long or a short stop delay, chosen at the wake. Whenever the enables are released, the divider restarts from phase zero, so the first bus pulse lands a fixed number of source ticks after the release.

Top module: `clkseq_top`

## Requirements
- R1: While `rst_n` is low, `rst_pin_n`, `cpu_en` and `per_en` are all low.
- R2: After reset, or after a power-on or low-voltage cause, `rst_pin_n` stays low until POR_CYCLES (default 4096) `osc_tick` strobes have been counted, whatever `src_sel` is. It goes high in the cycle after the last counted strobe. Both enables stay low while `rst_pin_n` is low.
- R3: While running, `cpu_en` and `per_en` pulse for one cycle once per four selected ticks. `src_sel`=0 selects `osc_tick` and `src_sel`=1 selects `pll_tick`.
- R4: The divider phase restarts at zero on every release. The first enable pulse follows the fourth selected tick that comes after the release.
- R5: A `wait_req` while running enters wait mode. In wait mode `cpu_en` stays low and `per_en` keeps pulsing. Any of `wake_irq`, `wake_brk` or `wake_rst` returns to running.
- R6: A `stop_req` while running enters stop mode and takes priority over a simultaneous `wait_req`. In stop mode both enables are low. `stop_req` during wait mode is ignored.
- R7: A wake in stop mode starts a stop-exit hold of STOP_SHORT (32) `osc_tick` strobes when `stop_short`=1 at the wake, and STOP_LONG (4096) otherwise. `rst_pin_n` stays high during this hold. Both enables stay low until it ends.
- R8: `por_req` or `lvi_req` in any state, including during a stop-exit hold or a running power-up hold, restarts the full power-up hold. `rst_pin_n` is low from the next cycle.
- R9: `cpu_en` is never high without `per_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| osc_tick | input | 1 | Strobe marking one oscillator clock edge |
| pll_tick | input | 1 | Strobe marking one PLL clock edge |
| src_sel | input | 1 | Source select: 0 oscillator, 1 PLL |
| por_req | input | 1 | Power-on reset cause |
| lvi_req | input | 1 | Low-voltage reset cause |
| stop_req | input | 1 | Request to enter stop mode |
| wait_req | input | 1 | Request to enter wait mode |
| wake_irq | input | 1 | Interrupt wake event |
| wake_brk | input | 1 | Break wake event |
| wake_rst | input | 1 | Reset wake event |
| stop_short | input | 1 | Stop-exit delay select: 1 short, 0 long |
| cpu_en | output | 1 | CPU bus clock enable pulse |
| per_en | output | 1 | Peripheral bus clock enable pulse |
| rst_pin_n | output | 1 | Active-low reset output drive |

## Verification
The bench builds the block with its default values: a divide of four, a 4096-tick power-up hold, and stop delays of 4096 and 32 ticks. These are the full hold lengths, so the bench checks the exact release cycle of both power-up and long stop-exit holds. It also runs a long hold with the oscillator strobe at half rate, which shows that only oscillator ticks are counted while the PLL is selected. The short delay keeps the stop-exit corner cheap enough to repeat, and an abort by a low-voltage cause is checked during a long stop-exit hold.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_RUN   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_STOP  = 3'd3,
        ST_STOPX = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       short_sel;
        logic       cpu_en;
        logic       per_en;
    } seq_regs_t;

endpackage

// File: rtl/clkseq_div.sv
module clkseq_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sel_i,
    input  logic osc_tick_i,
    input  logic pll_tick_i,
    output logic pulse_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
    } div_regs_t;

    div_regs_t regs_d, regs_q;
    logic      tick;

    always_comb begin
        regs_d = regs_q;
        tick   = sel_i ? pll_tick_i : osc_tick_i;
        pulse_o = run_i && tick && (regs_q.ph == LAST);
        if (!run_i) begin
            regs_d.ph = '0;
        end else if (tick) begin
            regs_d.ph = (regs_q.ph == LAST) ? '0 : regs_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/clkseq_hold.sv
module clkseq_hold #(
    parameter int POR_CYCLES = 4096,
    parameter int STOP_LONG  = 4096,
    parameter int STOP_SHORT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    input  logic pwrup_i,
    input  logic short_i,
    input  logic osc_tick_i,
    output logic done_o
);
    localparam int MAXA = (POR_CYCLES > STOP_LONG) ? POR_CYCLES : STOP_LONG;
    localparam int MAXC = (MAXA > STOP_SHORT) ? MAXA : STOP_SHORT;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_regs_t;

    hold_regs_t    regs_d, regs_q;
    logic [CW-1:0] limit;

    always_comb begin
        regs_d = regs_q;
        if (pwrup_i) begin
            limit = CW'(POR_CYCLES);
        end else if (short_i) begin
            limit = CW'(STOP_SHORT);
        end else begin
            limit = CW'(STOP_LONG);
        end
        done_o = count_i && !clear_i && osc_tick_i && (regs_q.cnt == limit - 1'b1);
        if (clear_i) begin
            regs_d.cnt = '0;
        end else if (count_i && osc_tick_i) begin
            regs_d.cnt = regs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
    import clkseq_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int POR_CYCLES = 4096,
    parameter int STOP_LONG  = 4096,
    parameter int STOP_SHORT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic pll_tick,
    input  logic src_sel,
    input  logic por_req,
    input  logic lvi_req,
    input  logic stop_req,
    input  logic wait_req,
    input  logic wake_irq,
    input  logic wake_brk,
    input  logic wake_rst,
    input  logic stop_short,
    output logic cpu_en,
    output logic per_en,
    output logic rst_pin_n
);
    seq_regs_t regs_d, regs_q;

    logic cause;
    logic wake;
    logic in_hold;
    logic running;
    logic hold_clear;
    logic hold_done;
    logic bus_pulse;

    assign cause      = por_req || lvi_req;
    assign wake       = wake_irq || wake_brk || wake_rst;
    assign in_hold    = (regs_q.st == ST_PWRUP) || (regs_q.st == ST_STOPX);
    assign running    = (regs_q.st == ST_RUN) || (regs_q.st == ST_WAIT);
    assign hold_clear = cause || !in_hold;

    clkseq_div #(
        .DIV(DIV)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (running),
        .sel_i     (src_sel),
        .osc_tick_i(osc_tick),
        .pll_tick_i(pll_tick),
        .pulse_o   (bus_pulse)
    );

    clkseq_hold #(
        .POR_CYCLES(POR_CYCLES),
        .STOP_LONG (STOP_LONG),
        .STOP_SHORT(STOP_SHORT)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (hold_clear),
        .count_i   (in_hold),
        .pwrup_i   (regs_q.st == ST_PWRUP),
        .short_i   (regs_q.short_sel),
        .osc_tick_i(osc_tick),
        .done_o    (hold_done)
    );

    always_comb begin
        regs_d = regs_q;
        if (cause) begin
            regs_d.st = ST_PWRUP;
        end else begin
            unique case (regs_q.st)
                ST_PWRUP: if (hold_done) regs_d.st = ST_RUN;
                ST_RUN: begin
                    if (stop_req) begin
                        regs_d.st = ST_STOP;
                    end else if (wait_req) begin
                        regs_d.st = ST_WAIT;
                    end
                end
                ST_WAIT: if (wake) regs_d.st = ST_RUN;
                ST_STOP: begin
                    if (wake) begin
                        regs_d.st        = ST_STOPX;
                        regs_d.short_sel = stop_short;
                    end
                end
                ST_STOPX: if (hold_done) regs_d.st = ST_RUN;
                default: regs_d.st = ST_PWRUP;
            endcase
        end
        regs_d.cpu_en = bus_pulse && (regs_d.st == ST_RUN);
        regs_d.per_en = bus_pulse && ((regs_d.st == ST_RUN) || (regs_d.st == ST_WAIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_PWRUP, short_sel: 1'b0, cpu_en: 1'b0, per_en: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cpu_en    = regs_q.cpu_en;
    assign per_en    = regs_q.per_en;
    assign rst_pin_n = (regs_q.st != ST_PWRUP);
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk
    import clkseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick,
    input logic       por_req,
    input logic       lvi_req,
    input logic       cpu_en,
    input logic       per_en,
    input logic       rst_pin_n,
    input seq_state_e st
);
    assert_cpu_needs_per_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> per_en);

    assert_cpu_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |=> !cpu_en);

    assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_n |-> (!cpu_en && !per_en));

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pin_n) |-> $past(osc_tick));

    assert_cause_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req || lvi_req) |=> !rst_pin_n);

    assert_wait_cpu_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !cpu_en);

    assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> (!cpu_en && !per_en));

    assert_stopx_pin_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOPX) |-> (rst_pin_n && !cpu_en && !per_en));
endmodule

bind clkseq_top clkseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .por_req  (por_req),
    .lvi_req  (lvi_req),
    .cpu_en   (cpu_en),
    .per_en   (per_en),
    .rst_pin_n(rst_pin_n),
    .st       (regs_q.st)
);

// File: tb/clkseq_top_tb.sv
`timescale 1ns/1ps
module clkseq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0, pll_tick = 1'b0, src_sel = 1'b0;
    logic por_req = 1'b0, lvi_req = 1'b0, stop_req = 1'b0, wait_req = 1'b0;
    logic wake_irq = 1'b0, wake_brk = 1'b0, wake_rst = 1'b0, stop_short = 1'b0;
    logic cpu_en, per_en, rst_pin_n;

    int total = 0;
    int bad = 0;
    int osc_mode = 1;
    int gcnt = 0;
    string tag = "R1";
    bit done = 0;

    // behavioural model: 0 pwrup, 1 run, 2 wait, 3 stop, 4 stop-exit
    int m_st = 0, m_cnt = 0, m_ph = 0;
    bit m_short = 0;
    bit e_cpu = 0, e_per = 0, e_rst = 0;

    always #2 clk = ~clk;

    clkseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .src_sel(src_sel), .por_req(por_req), .lvi_req(lvi_req),
        .stop_req(stop_req), .wait_req(wait_req), .wake_irq(wake_irq),
        .wake_brk(wake_brk), .wake_rst(wake_rst), .stop_short(stop_short),
        .cpu_en(cpu_en), .per_en(per_en), .rst_pin_n(rst_pin_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit cause, wake, tk, pulse, hold, dn;
        int lim, nst;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ph = 0; m_short = 0;
            e_cpu = 0; e_per = 0; e_rst = 0;
        end else begin
            cause = por_req || lvi_req;
            wake  = wake_irq || wake_brk || wake_rst;
            tk    = src_sel ? pll_tick : osc_tick;
            pulse = (m_st == 1 || m_st == 2) && tk && (m_ph == 3);
            hold  = (m_st == 0 || m_st == 4);
            lim   = (m_st == 0) ? 4096 : (m_short ? 32 : 4096);
            dn    = hold && !cause && osc_tick && (m_cnt == lim - 1);
            if (m_st == 1 || m_st == 2) begin
                if (tk) m_ph = (m_ph + 1) % 4;
            end else m_ph = 0;
            if (cause || !hold) m_cnt = 0;
            else if (osc_tick) m_cnt++;
            nst = m_st;
            if (cause) nst = 0;
            else case (m_st)
                0: if (dn) nst = 1;
                1: if (stop_req) nst = 3; else if (wait_req) nst = 2;
                2: if (wake) nst = 1;
                3: if (wake) begin nst = 4; m_short = stop_short; end
                4: if (dn) nst = 1;
                default: nst = 0;
            endcase
            m_st  = nst;
            e_cpu = pulse && (nst == 1);
            e_per = pulse && (nst == 1 || nst == 2);
            e_rst = (nst != 0);
        end
        #1;
        if (!done) begin
            check(tag, "cpu_en", int'(cpu_en), int'(e_cpu));
            check(tag, "per_en", int'(per_en), int'(e_per));
            check(tag, "rst_pin_n", int'(rst_pin_n), int'(e_rst));
            if (cpu_en && !per_en) check("R9", "cpu_en without per_en", 1, 0);
        end
    end

    // tick generator, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            gcnt++;
            osc_tick = (osc_mode == 1) ? 1'b1 : ((gcnt % 2) == 0);
            pll_tick = ((gcnt % 3) != 2);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse1(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 60000);
        total++; bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tag = "R1";
        cyc(4);
        check("R1", "rst_pin_n in reset", int'(rst_pin_n), 0);
        check("R1", "cpu_en in reset", int'(cpu_en), 0);
        check("R1", "per_en in reset", int'(per_en), 0);
        // release at a negedge; osc ticks every cycle from here
        @(negedge clk); rst_n = 1'b1;
        tag = "R2";
        repeat (4095) @(posedge clk);
        #1 check("R2", "pin low before last tick", int'(rst_pin_n), 0);
        @(posedge clk);
        #1 check("R2", "pin high after 4096 ticks", int'(rst_pin_n), 1);
        tag = "R4";
        repeat (3) @(posedge clk);
        #1 check("R4", "no pulse before 4th tick", int'(cpu_en), 0);
        @(posedge clk);
        #1 check("R4", "first pulse after 4th tick", int'(cpu_en), 1);

        tag = "R3";
        cyc(40);
        src_sel = 1'b1;
        cyc(60);

        tag = "R5";
        pulse1(wait_req);
        cyc(40);
        check("R5", "cpu_en low in wait", int'(cpu_en), 0);
        pulse1(wake_irq);
        cyc(20);

        tag = "R6";
        @(negedge clk); stop_req = 1'b1; wait_req = 1'b1;
        @(negedge clk); stop_req = 1'b0; wait_req = 1'b0;
        cyc(30);
        pulse1(wait_req);
        cyc(10);

        tag = "R7";
        stop_short = 1'b1;
        pulse1(wake_brk);
        stop_short = 1'b0;
        cyc(20);
        check("R7", "pin high during stop-exit", int'(rst_pin_n), 1);
        cyc(40);
        pulse1(stop_req);
        cyc(5);
        osc_mode = 2;
        pulse1(wake_rst);
        cyc(8300);
        osc_mode = 1;
        cyc(30);

        tag = "R8";
        pulse1(stop_req);
        cyc(5);
        pulse1(wake_irq);
        cyc(100);
        @(negedge clk); lvi_req = 1'b1;
        @(posedge clk);
        #1 check("R8", "pin low after cause", int'(rst_pin_n), 0);
        @(negedge clk); lvi_req = 1'b0;
        cyc(1000);
        pulse1(por_req);
        cyc(4200);
        check("R8", "pin released after restart", int'(rst_pin_n), 1);
        cyc(50);
        finish_run();
    end
endmodule